// File: doc/BRIEF.md
# Converter Host Bus Port

This block sits between a processor bus and the sequencer of a 12-bit successive-approximation converter. It samples five host control lines through two-flop synchronizers: an active-high enable, an active-low select, a read/convert line, a bus-width line and a byte-address bit. It decodes them into either a one-clock conversion request, which carries a length select, or a read of the stored result.

The result is captured from the sequencer when its busy flag falls. It is presented on a 12-bit data output with a matching per-bit drive enable; a cleared enable bit stands for a released (high-impedance) line.

On a wide bus all twelve bits are driven together. On a byte-wide bus the data is left-justified in bits [11:4]:
- With the address bit low, the port returns the upper eight result bits.
- With the address bit high, it returns the lower four result bits followed by four zeros.
- Bits [3:0] are released.

Control and status pins are plain levels; there is no streaming interface and no back-pressure. The block never stalls, and every output is a pure function of the synchronized inputs and the stored result.

Top module: `adc_host_port`

## Requirements
- R1: When the synchronized enable is low or the synchronized select is high, all drive-enable bits are 0, the data output is 0, and no conversion request is issued.
- R2: Enable high, select low and read/convert low form a start condition. The block issues a request on `conv_start` and, in the same cycle, sets `conv_short` to the address bit: 0 requests 12 bits, 1 requests 8 bits. `conv_short` holds its value until the next request.
- R3: `conv_start` is high for exactly one clock, on the first cycle the start condition is seen. It does not repeat while the condition is held. A new request needs the condition to drop and return.
- R4: During a read (enable high, select low, read/convert high) with the width line high, all 12 drive bits are 1 and the data equals the stored result.
- R5: During a read with the width line low and the address bit low, bits [11:4] carry result[11:4] and are driven. Bits [3:0] are 0 and not driven.
- R6: During a read with the width line low and the address bit high, bits [11:4] carry {result[3:0], 4'b0000} and are driven. Bits [3:0] are 0 and not driven.
- R7: A change of the address bit during an ongoing read changes the selected byte without the read being deselected.
- R8: The stored result loads `seq_result` only on a clock where `seq_busy` is low and was high on the previous clock. Reads before that return the previous value, which is 0 after reset.
- R9: If read/convert is high when enable and select become active, a read takes place and no conversion request is issued.
- R10: Each host input passes two synchronizer flops and one output register. A change applied before clock edge n shows on `conv_start`, `conv_short`, `bus_data` and `bus_drive` after edge n+2. After reset all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| host_ce | input | 1 | Host enable, active high |
| host_cs_n | input | 1 | Host select, active low |
| host_rdconv | input | 1 | 1 = read, 0 = convert |
| host_wide | input | 1 | 1 = 12-bit bus, 0 = byte bus |
| host_a0 | input | 1 | Byte address / length select |
| seq_busy | input | 1 | Sequencer conversion in progress |
| seq_result | input | 12 | Sequencer result, sampled when busy falls |
| conv_start | output | 1 | One-clock conversion request |
| conv_short | output | 1 | Length select sent with the request (1 = 8 bits) |
| bus_data | output | 12 | Result data toward the host bus |
| bus_drive | output | 12 | Per-bit drive enable (0 = released) |

## Verification
A host input change made before edge n is due at the outputs after edge n+2. A busy fall seen at edge k first affects read data after edge k+1. The bench keeps a behavioural model that holds a short history of the sampled host inputs and a model of the stored result. It advances the model on every rising edge and compares all four outputs at each following falling edge, so every cycle is checked at exactly the latency the requirements give. One extra directed check counts the edges from a start condition to its request, to pin down the R10 latency independently of the model.

// File: rtl/adc_port_pkg.sv
package adc_port_pkg;

  // Synchronized host control word; field order fixes the bit order.
  typedef struct packed {
    logic ce;
    logic cs_n;
    logic rdconv;
    logic wide;
    logic a0;
  } host_ctrl_t;

  localparam int HOST_CTRL_W = $bits(host_ctrl_t);

  // Idle values loaded into the synchronizer at reset: deselected, read side.
  localparam logic [HOST_CTRL_W-1:0] HOST_CTRL_IDLE = 5'b01100;

  typedef enum logic [1:0] {
    OP_IDLE  = 2'd0,
    OP_START = 2'd1,
    OP_READ  = 2'd2
  } host_op_t;

  function automatic host_op_t decode_op(host_ctrl_t c);
    if (!c.ce || c.cs_n) return OP_IDLE;
    if (c.rdconv)        return OP_READ;
    return OP_START;
  endfunction

endpackage

// File: rtl/adc_port_sync.sv
module adc_port_sync #(
  parameter int                  W       = 5,
  parameter int                  STAGES  = 2,
  parameter logic [W-1:0]        RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_async,
  output logic [W-1:0] q_sync
);

  for (genvar b = 0; b < W; b++) begin : g_bit
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= {STAGES{RST_VAL[b]}};
      else        chain <= {chain[STAGES-2:0], d_async[b]};
    end
    assign q_sync[b] = chain[STAGES-1];
  end

endmodule

// File: rtl/adc_port_decode.sv
module adc_port_decode
  import adc_port_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  host_ctrl_t ctrl_s,
  output logic       read_en,
  output logic       conv_start,
  output logic       conv_short
);

  host_op_t op;
  logic     start_cond;
  logic     start_cond_q;

  assign op         = decode_op(ctrl_s);
  assign start_cond = (op == OP_START);
  assign read_en    = (op == OP_READ);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      start_cond_q <= 1'b0;
      conv_start   <= 1'b0;
      conv_short   <= 1'b0;
    end else begin
      start_cond_q <= start_cond;
      conv_start   <= start_cond && !start_cond_q;
      if (start_cond && !start_cond_q) conv_short <= ctrl_s.a0;
    end
  end

  // R3
  start_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |=> !conv_start);

  // R9
  start_needs_convert_chk: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |-> (!$past(ctrl_s.rdconv) && $past(ctrl_s.ce) && !$past(ctrl_s.cs_n)));

  // R2
  short_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !conv_start |=> (conv_start || $stable(conv_short)));

endmodule

// File: rtl/adc_port_result.sv
module adc_port_result #(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         seq_busy,
  input  logic [W-1:0] seq_result,
  output logic [W-1:0] res_q
);

  logic busy_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      res_q  <= '0;
    end else begin
      busy_q <= seq_busy;
      if (busy_q && !seq_busy) res_q <= seq_result;
    end
  end

  // R8
  hold_while_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    seq_busy |=> $stable(res_q));

  // R8
  load_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(seq_busy) |=> (res_q == $past(seq_result)));

endmodule

// File: rtl/adc_port_format.sv
module adc_port_format #(
  parameter int W      = 12,
  parameter int BYTE_W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         read_en,
  input  logic         wide,
  input  logic         a0,
  input  logic [W-1:0] res,
  output logic [W-1:0] bus_data,
  output logic [W-1:0] bus_drive
);

  localparam int LO_W  = W - BYTE_W;       // bits left for the odd address
  localparam int PAD_W = BYTE_W - LO_W;    // trailing zeros after them

  logic [BYTE_W-1:0] hi_byte, lo_byte;
  logic [W-1:0]      nxt_data, nxt_drive;

  assign hi_byte = res[W-1 -: BYTE_W];
  assign lo_byte = {res[LO_W-1:0], {PAD_W{1'b0}}};

  always_comb begin
    nxt_data  = '0;
    nxt_drive = '0;
    if (read_en) begin
      if (wide) begin
        nxt_data  = res;
        nxt_drive = '1;
      end else begin
        nxt_drive[W-1 -: BYTE_W] = '1;
        nxt_data[W-1 -: BYTE_W]  = a0 ? lo_byte : hi_byte;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_data  <= '0;
      bus_drive <= '0;
    end else begin
      bus_data  <= nxt_data;
      bus_drive <= nxt_drive;
    end
  end

  // R1
  idle_released_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !read_en |=> (bus_drive == '0 && bus_data == '0));

  // R5
  narrow_low_released_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (read_en && !wide) |=> (bus_drive[LO_W-1:0] == '0 && bus_data[LO_W-1:0] == '0));

  // R6
  odd_trailing_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (read_en && !wide && a0) |=> (bus_data[LO_W +: PAD_W] == '0));

  // R4
  wide_all_driven_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (read_en && wide) |=> (bus_drive == '1 && bus_data == $past(res)));

endmodule

// File: rtl/adc_host_port.sv
module adc_host_port
  import adc_port_pkg::*;
#(
  parameter int RES_W  = 12,
  parameter int BYTE_W = 8,
  parameter int SYNC_N = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             host_ce,
  input  logic             host_cs_n,
  input  logic             host_rdconv,
  input  logic             host_wide,
  input  logic             host_a0,
  input  logic             seq_busy,
  input  logic [RES_W-1:0] seq_result,
  output logic             conv_start,
  output logic             conv_short,
  output logic [RES_W-1:0] bus_data,
  output logic [RES_W-1:0] bus_drive
);

  host_ctrl_t             ctrl_raw, ctrl_s;
  logic [HOST_CTRL_W-1:0] ctrl_s_bits;
  logic                   read_en;
  logic [RES_W-1:0]       res_q;

  assign ctrl_raw = '{ce: host_ce, cs_n: host_cs_n, rdconv: host_rdconv,
                      wide: host_wide, a0: host_a0};

  adc_port_sync #(
    .W(HOST_CTRL_W), .STAGES(SYNC_N), .RST_VAL(HOST_CTRL_IDLE)
  ) u_sync (
    .clk(clk), .rst_n(rst_n), .d_async(ctrl_raw), .q_sync(ctrl_s_bits)
  );

  assign ctrl_s = host_ctrl_t'(ctrl_s_bits);

  adc_port_decode u_dec (
    .clk(clk), .rst_n(rst_n), .ctrl_s(ctrl_s), .read_en(read_en),
    .conv_start(conv_start), .conv_short(conv_short)
  );

  adc_port_result #(.W(RES_W)) u_res (
    .clk(clk), .rst_n(rst_n), .seq_busy(seq_busy),
    .seq_result(seq_result), .res_q(res_q)
  );

  adc_port_format #(.W(RES_W), .BYTE_W(BYTE_W)) u_fmt (
    .clk(clk), .rst_n(rst_n), .read_en(read_en), .wide(ctrl_s.wide),
    .a0(ctrl_s.a0), .res(res_q), .bus_data(bus_data), .bus_drive(bus_drive)
  );

endmodule

// File: tb/tb_adc_host_port.sv
module tb_adc_host_port;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        host_ce = 1'b0, host_cs_n = 1'b1, host_rdconv = 1'b1;
  logic        host_wide = 1'b0, host_a0 = 1'b0;
  logic        seq_busy = 1'b0;
  logic [11:0] seq_result = '0;
  logic        conv_start, conv_short;
  logic [11:0] bus_data, bus_drive;

  always #5 clk = ~clk;

  adc_host_port dut (
    .clk(clk), .rst_n(rst_n), .host_ce(host_ce), .host_cs_n(host_cs_n),
    .host_rdconv(host_rdconv), .host_wide(host_wide), .host_a0(host_a0),
    .seq_busy(seq_busy), .seq_result(seq_result), .conv_start(conv_start),
    .conv_short(conv_short), .bus_data(bus_data), .bus_drive(bus_drive)
  );

  int    n_cmp = 0;
  int    n_bad = 0;
  string cur_req = "R10";
  bit    done = 1'b0;

  // ---- behavioural reference model ----
  typedef struct packed { logic ce, cs_n, rdconv, wide, a0; } hin_t;
  hin_t hist[$];
  logic [11:0] m_res;
  logic        m_busy_prev;
  logic        e_start, e_short;
  logic [11:0] e_data, e_drive;

  function automatic bit is_start(hin_t h);
    return h.ce && !h.cs_n && !h.rdconv;
  endfunction

  function automatic bit is_read(hin_t h);
    return h.ce && !h.cs_n && h.rdconv;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      hist = '{5'b01100, 5'b01100, 5'b01100};
      m_res = '0; m_busy_prev = 1'b0;
      e_start = 0; e_short = 0; e_data = '0; e_drive = '0;
    end else begin
      // hist[1]: inputs two edges back, hist[2]: three edges back
      e_start = is_start(hist[1]) && !is_start(hist[2]);
      if (e_start) e_short = hist[1].a0;
      e_data = '0; e_drive = '0;
      if (is_read(hist[1])) begin
        if (hist[1].wide) begin
          e_drive = 12'hFFF; e_data = m_res;
        end else begin
          e_drive = 12'hFF0;
          e_data  = hist[1].a0 ? {m_res[3:0], 8'h00} : {m_res[11:4], 4'h0};
        end
      end
      if (m_busy_prev && !seq_busy) m_res = seq_result;
      m_busy_prev = seq_busy;
      void'(hist.pop_back());
      hist.push_front(hin_t'({host_ce, host_cs_n, host_rdconv, host_wide, host_a0}));
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      n_cmp++;
      if (conv_start !== e_start || conv_short !== e_short ||
          bus_data !== e_data || bus_drive !== e_drive) begin
        n_bad++;
        $display("FAIL %s: got start=%b short=%b data=%h drive=%h exp start=%b short=%b data=%h drive=%h",
                 cur_req, conv_start, conv_short, bus_data, bus_drive,
                 e_start, e_short, e_data, e_drive);
      end
    end
  end

  // ---- stimulus helpers ----
  task automatic host(input logic ce, input logic cs_n, input logic rc,
                      input logic wide, input logic a0, input int cyc);
    @(negedge clk);
    host_ce = ce; host_cs_n = cs_n; host_rdconv = rc; host_wide = wide; host_a0 = a0;
    repeat (cyc - 1) @(negedge clk);
  endtask

  task automatic convert(input logic [11:0] val, input int cyc);
    @(negedge clk); seq_busy = 1'b1; seq_result = 12'h000;
    repeat (cyc) @(negedge clk);
    seq_result = val; seq_busy = 1'b0;
  endtask

  task automatic direct(input string req, input bit ok, input logic [11:0] got,
                        input logic [11:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: got %h exp %h", req, got, exp);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R10 reset state
    direct("R10", conv_start === 0 && bus_drive === 0 && bus_data === 0,
           bus_drive, 12'h000);
    rst_n = 1'b1;

    cur_req = "R1";
    host(0, 0, 0, 1, 0, 5);  // enable low
    host(1, 1, 0, 1, 0, 5);  // select high
    host(0, 1, 1, 0, 1, 5);

    cur_req = "R8";
    convert(12'hA5C, 4);
    host(1, 0, 1, 1, 0, 6);  // R4 wide read
    cur_req = "R4";
    host(1, 0, 1, 1, 1, 4);
    cur_req = "R5";
    host(1, 0, 1, 0, 0, 5);
    cur_req = "R7";
    host(1, 0, 1, 0, 1, 4);  // address bit flips, read stays active
    host(1, 0, 1, 0, 0, 4);
    cur_req = "R6";
    host(1, 0, 1, 0, 1, 5);
    host(0, 1, 1, 0, 0, 4);

    // R2/R3: 12-bit start held several cycles, then 8-bit start
    cur_req = "R3";
    host(1, 0, 0, 1, 0, 8);
    host(0, 1, 0, 1, 0, 4);
    cur_req = "R2";
    host(1, 0, 0, 0, 1, 6);
    host(1, 1, 0, 0, 0, 4);

    // R10 explicit latency from start condition to request
    cur_req = "R10";
    @(negedge clk); host_ce = 1; host_cs_n = 0; host_rdconv = 0; host_a0 = 0;
    @(negedge clk); direct("R10", conv_start === 1'b0, {11'd0, conv_start}, 12'd0);
    @(negedge clk); direct("R10", conv_start === 1'b0, {11'd0, conv_start}, 12'd0);
    @(negedge clk); direct("R10", conv_start === 1'b1, {11'd0, conv_start}, 12'd1);
    host(0, 1, 1, 1, 0, 4);

    // R8: reads during busy return previous result
    cur_req = "R8";
    fork
      convert(12'h3E7, 10);
      host(1, 0, 1, 1, 0, 16);
    join
    host(1, 0, 1, 0, 1, 5);
    host(0, 1, 1, 0, 0, 3);

    // R9: read/convert high on selection, then deselect: no request
    cur_req = "R9";
    host(1, 0, 1, 0, 0, 6);
    host(0, 1, 1, 0, 0, 4);
    host(1, 1, 1, 1, 0, 3);
    host(1, 0, 1, 1, 0, 5);
    host(1, 1, 1, 1, 0, 4);

    cur_req = "R1";
    host(0, 0, 1, 1, 1, 5);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_bad++;
      $display("FAIL watchdog: got timeout exp completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule